// File: doc/BRIEF.md
# USB Legacy SMI Event Register

This block is a 32-bit control/status register that sits beside a USB host controller and decides when the controller raises a System Management Interrupt (SMI). It has two kinds of source. Three event bits latch and stay set: a configuration write to the base address register, a configuration write to the command register, and any toggle of the OS-ownership semaphore. Six further bits are live copies of the controller's own interrupt status lines.

Every source has its own enable bit in the same register. The single SMI output is high whenever any enabled source is set. Firmware reads the register to see what caused the SMI. It then writes 1 to the latched event bits to clear them, and it changes the enables with the same write.

Top module: `usb_legacy_smi`

## Requirements
- R1: After reset, with all status inputs low, the register reads 0000_0000h and `smi_o` is low.
- R2: Bit 31 becomes 1 in the cycle after `bar_wr_evt` is sampled high. It then stays set until a register write with `wr_data[31]`=1 clears it.
- R3: Bit 30 becomes 1 in the cycle after `cmd_wr_evt` is sampled high. It then stays set until a register write with `wr_data[30]`=1 clears it.
- R4: Bit 29 becomes 1 in the cycle after `os_owned` is sampled with a value different from the one sampled on the previous edge. Both 0-to-1 and 1-to-0 count. The first edge after reset is never treated as a change. A write with `wr_data[29]`=1 clears the bit.
- R5: Writing 0 to bit 31, 30 or 29 leaves that bit unchanged.
- R6: Bits 21:16 always show `hc_status[5:0]` as it is in the same cycle. The mapping is: 21 async advance, 20 host system error, 19 frame list rollover, 18 port change detect, 17 USB error, 16 transfer complete.
- R7: Bits 15, 14 and 13 are read/write enables for event bits 31, 30 and 29, in that order. They are loaded on every register write.
- R8: Bits 5:0 are read/write enables for shadow bits 21:16. Bit 5 gates 21 and bit 0 gates 16, with the bits in between paired in the same order. They are loaded on every register write.
- R9: `smi_o` is the combinational OR of every source bit ANDed with its enable. It follows a change in `hc_status` or in the enables with no added cycle.
- R10: If an event sets a latched bit in the same cycle as a write-1 clears that bit, the bit ends up set.
- R11: Bits 28:22 and 12:6 always read 0. Writes to those bits and to bits 21:16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| bar_wr_evt | input | 1 | One-cycle pulse: base address register was written |
| cmd_wr_evt | input | 1 | One-cycle pulse: command register was written |
| os_owned | input | 1 | OS-ownership semaphore level |
| hc_status | input | 6 | Live controller status, bit 5 async advance down to bit 0 complete |
| rd_data | output | 32 | Current register value |
| smi_o | output | 1 | SMI request |

## Verification
The assertions assume three things about the inputs. Every input changes only between clock edges. `hc_status` is a level signal that is free to change in any cycle. `os_owned` is a level signal, so a toggle is judged against the value held on the previous edge. The bench meets these assumptions by driving all inputs on the falling edge and holding them across the rising edge. Its cases include a semaphore already high when reset is released, a clear and a set of the same bit in one cycle, and an all-ones write that reaches the reserved and read-only positions.

// File: rtl/usb_smi_pkg.sv
package usb_smi_pkg;
    localparam int REG_W      = 32;
    localparam int EVT_N      = 3;
    localparam int SHD_N      = 6;
    localparam int EVT_LSB    = 29;
    localparam int EVT_EN_LSB = 13;
    localparam int SHD_LSB    = 16;
    localparam int SHD_EN_LSB = 0;
    localparam int EVT_MSB    = EVT_LSB + EVT_N - 1;
    localparam int EVT_EN_MSB = EVT_EN_LSB + EVT_N - 1;
    localparam int SHD_MSB    = SHD_LSB + SHD_N - 1;
    localparam int SHD_EN_MSB = SHD_EN_LSB + SHD_N - 1;

    typedef struct packed {
        logic [EVT_N-1:0] evt;
        logic [EVT_N-1:0] evt_en;
        logic [SHD_N-1:0] shd_en;
    } smi_state_t;

    function automatic logic [REG_W-1:0] pack_read(input smi_state_t s,
                                                   input logic [SHD_N-1:0] shd);
        logic [REG_W-1:0] r;
        r = '0;
        r[EVT_MSB:EVT_LSB]       = s.evt;
        r[EVT_EN_MSB:EVT_EN_LSB] = s.evt_en;
        r[SHD_MSB:SHD_LSB]       = shd;
        r[SHD_EN_MSB:SHD_EN_LSB] = s.shd_en;
        return r;
    endfunction
endpackage

// File: rtl/usb_smi_sticky.sv
module usb_smi_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    // Per-bit sticky flag; a set in the same cycle as a clear wins.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_smi_toggle_det.sv
module usb_smi_toggle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic chg_o
);
    logic level_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            level_q  <= level_i;
            primed_q <= 1'b1;
        end
    end

    // A change counts only once a previous sample exists.
    assign chg_o = primed_q && (level_i != level_q);
endmodule

// File: rtl/usb_smi_en_reg.sv
module usb_smi_en_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/usb_legacy_smi.sv
module usb_legacy_smi
    import usb_smi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bar_wr_evt,
    input  logic             cmd_wr_evt,
    input  logic             os_owned,
    input  logic [SHD_N-1:0] hc_status,
    output logic [REG_W-1:0] rd_data,
    output logic             smi_o
);
    smi_state_t       st;
    logic             os_chg;
    logic [EVT_N-1:0] evt_set;
    logic [EVT_N-1:0] evt_clr;
    logic             unused_wr_bits;

    // Reserved and read-only positions of the write data are not stored.
    assign unused_wr_bits = ^{wr_data[EVT_LSB-1:EVT_EN_MSB+1],
                              wr_data[EVT_EN_LSB-1:SHD_EN_MSB+1]};

    usb_smi_toggle_det u_sem (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (os_owned),
        .chg_o   (os_chg)
    );

    // The order here is bar, cmd, semaphore, from the top bit down.
    assign evt_set = {bar_wr_evt, cmd_wr_evt, os_chg};
    assign evt_clr = wr_en ? wr_data[EVT_MSB:EVT_LSB] : '0;

    usb_smi_sticky #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .q_o   (st.evt)
    );

    usb_smi_en_reg #(.N(EVT_N)) u_evt_en (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_en),
        .d_i   (wr_data[EVT_EN_MSB:EVT_EN_LSB]),
        .q_o   (st.evt_en)
    );

    usb_smi_en_reg #(.N(SHD_N)) u_shd_en (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_en),
        .d_i   (wr_data[SHD_EN_MSB:SHD_EN_LSB]),
        .q_o   (st.shd_en)
    );

    always_comb begin
        rd_data = pack_read(st, hc_status);
        smi_o   = (|(st.evt & st.evt_en)) | (|(hc_status & st.shd_en));
    end
endmodule

// File: rtl/usb_legacy_smi_chk.sv
module usb_legacy_smi_chk
    import usb_smi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             bar_wr_evt,
    input logic             cmd_wr_evt,
    input logic             os_owned,
    input logic [SHD_N-1:0] hc_status,
    input logic [REG_W-1:0] rd_data,
    input logic             smi_o
);
    a_r2_bar_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bar_wr_evt |=> rd_data[31]);

    a_r3_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[30] && !cmd_wr_evt) |=> !rd_data[30]);

    a_r4_sem_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (os_owned != $past(os_owned))) |=> rd_data[29]);

    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31] && !(wr_en && wr_data[31])) |=> rd_data[31]);

    a_r6_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[21:16] == hc_status);

    a_r9_smi_or: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o == ((|(rd_data[31:29] & rd_data[15:13])) |
                  (|(rd_data[21:16] & rd_data[5:0]))));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31] && bar_wr_evt) |=> rd_data[31]);

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[28:22] == '0) && (rd_data[12:6] == '0));
endmodule

bind usb_legacy_smi usb_legacy_smi_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .bar_wr_evt (bar_wr_evt),
    .cmd_wr_evt (cmd_wr_evt),
    .os_owned   (os_owned),
    .hc_status  (hc_status),
    .rd_data    (rd_data),
    .smi_o      (smi_o)
);

// File: tb/usb_legacy_smi_bench.sv
`timescale 1ns/1ps
module usb_legacy_smi_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bar_wr_evt = 1'b0;
    logic        cmd_wr_evt = 1'b0;
    logic        os_owned = 1'b0;
    logic [5:0]  hc_status = '0;
    logic [31:0] rd_data;
    logic        smi_o;

    always #4 clk = ~clk;

    usb_legacy_smi u_usb_legacy_smi (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bar_wr_evt(bar_wr_evt), .cmd_wr_evt(cmd_wr_evt), .os_owned(os_owned),
        .hc_status(hc_status), .rd_data(rd_data), .smi_o(smi_o)
    );

    typedef struct {
        logic [31:0] rd;
        logic        smi;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Bench-side model state, built from the requirements.
    logic [2:0] m_evt;
    logic [2:0] m_en3;
    logic [5:0] m_en6;
    logic       m_osq;
    logic       m_primed;

    // Monitor: compares 2 ns after each rising edge, before the next drive.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (rd_data !== e.rd || smi_o !== e.smi) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h smi=%b expected rd=%h smi=%b",
                             e.tag, rd_data, smi_o, e.rd, e.smi);
                end
            end
        end
    end

    task automatic drv(input logic we, input logic [31:0] wd, input logic bar,
                       input logic cmd, input logic os, input logic [5:0] st,
                       input string tag);
        logic chg;
        logic [2:0] clr;
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_data = wd; bar_wr_evt = bar; cmd_wr_evt = cmd;
        os_owned = os; hc_status = st;
        @(posedge clk);
        chg = m_primed && (os != m_osq);
        m_osq = os; m_primed = 1'b1;
        clr = we ? wd[31:29] : 3'b000;
        m_evt = (m_evt & ~clr) | {bar, cmd, chg};
        if (we) begin m_en3 = wd[15:13]; m_en6 = wd[5:0]; end
        e.rd  = {m_evt, 7'b0, st, m_en3, 7'b0, m_en6};
        e.smi = (|(m_evt & m_en3)) | (|(st & m_en6));
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset(input logic os);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; wr_data = '0; bar_wr_evt = 0; cmd_wr_evt = 0;
        os_owned = os; hc_status = '0;
        repeat (3) @(posedge clk);
        m_evt = '0; m_en3 = '0; m_en6 = '0; m_osq = 1'b0; m_primed = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_fail++; n_run++;
                    $display("FAIL watchdog: actual=expired expected=finish");
                    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                    $finish;
                end
            end
        join_none

        do_reset(1'b0);
        drv(0, '0, 0, 0, 0, '0, "R1 reset value");
        // R2 bar event latches, sticky, W1C
        drv(0, '0, 1, 0, 0, '0, "R2 bar sets bit31");
        drv(0, '0, 0, 0, 0, '0, "R2 bit31 sticky");
        drv(1, 32'h0000_0000, 0, 0, 0, '0, "R5 write 0 keeps bit31");
        drv(1, 32'h8000_0000, 0, 0, 0, '0, "R2 write1 clears bit31");
        // R3 cmd event
        drv(0, '0, 0, 1, 0, '0, "R3 cmd sets bit30");
        drv(1, 32'h4000_0000, 0, 0, 0, '0, "R3 write1 clears bit30");
        // R4 semaphore both directions
        drv(0, '0, 0, 0, 1, '0, "R4 sem rise sets bit29");
        drv(1, 32'h2000_0000, 0, 0, 1, '0, "R4 clear bit29 sem steady");
        drv(0, '0, 0, 0, 0, '0, "R4 sem fall sets bit29");
        drv(1, 32'h2000_0000, 0, 0, 0, '0, "R4 clear bit29 again");
        // R7 event enables drive SMI
        drv(1, 32'h0000_8000, 1, 0, 0, '0, "R7 bar enabled raises smi");
        drv(1, 32'h0000_4000, 0, 0, 0, '0, "R7 bar enable off drops smi");
        drv(0, '0, 0, 1, 0, '0, "R7 cmd enabled smi");
        drv(1, 32'hE000_2000, 0, 0, 1, '0, "R7 sem enable with event");
        drv(1, 32'h2000_0000, 0, 0, 1, '0, "R7 clear drops smi");
        // R6 shadow mirror patterns, R8 per-bit enables, R9 no latency
        drv(0, '0, 0, 0, 1, 6'b101010, "R6 shadow pattern a");
        drv(0, '0, 0, 0, 1, 6'b010101, "R6 shadow pattern b");
        for (int i = 0; i < 6; i++) begin
            drv(1, 32'h1 << i, 0, 0, 1, 6'h01 << i, $sformatf("R8 enable bit %0d matches", i));
            drv(0, '0, 0, 0, 1, 6'h3F & ~(6'h01 << i), $sformatf("R9 status %0d low no smi", i));
        end
        drv(1, 32'h0000_0020, 0, 0, 1, 6'b100000, "R8 async advance immediate smi");
        drv(0, '0, 0, 0, 1, 6'b000000, "R9 smi follows status drop");
        // R10 set beats clear
        drv(1, 32'hE000_0000, 1, 1, 0, '0, "R10 set wins bar cmd sem");
        drv(1, 32'hE000_0000, 0, 0, 0, '0, "R10 then clear");
        // R11 reserved and read-only positions ignore writes
        drv(1, 32'hFFFF_FFFF, 0, 0, 0, 6'b000000, "R11 all ones write");
        drv(1, 32'h1FFF_1FC0, 0, 0, 0, 6'b000011, "R11 reserved write clears enables");
        // R4 semaphore high across reset release is not a change
        do_reset(1'b1);
        drv(0, '0, 0, 0, 1, '0, "R4 no edge after reset");
        drv(0, '0, 0, 0, 1, '0, "R1 steady after reset");
        @(posedge clk); #3;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule